// File: doc/BRIEF.md
# H-Bridge Fault Latch and Sleep Supervisor

This block sits between the per-channel control inputs of a set of H-bridge half-channels and their gate drivers. For every channel it turns a direction bit and an enable bit into a high-side and a low-side gate enable. It never turns both on at once. When a channel's overcurrent detector fires, the block latches a fault for that channel, turns that channel's gates off, and pulls a shared active-low fault flag low. The latched faults stay set until a falling edge arrives on a dedicated clear input. A steady level on that input clears nothing. The clear input is passed through a two-flop synchroniser, and the edge is taken from the synchronised value.

An active-low sleep input puts the block into a low-power state. In that state the gate enables and the charge-pump enable are off, the internal register enables are frozen, and every other input is ignored. When the sleep input goes high again, the charge pump restarts at once. The gates stay off for a programmable wake-up time, by default 250 000 cycles, which is 1 ms at 250 MHz. After that time the channels follow their inputs again. A low level on the reset input or on the sleep input keeps the bridges off, so both must be driven high for operation. The asynchronous reset is released through a two-stage synchroniser.

Top module: `bridge_guard`

## Requirements
- R1: While the reset input is low, every gate enable is 0, the charge-pump enable is 0 and the fault flag is 1 (no fault).
- R2: In normal operation, a channel without a latched fault drives both gate enables to 0 when its enable is 0. With its enable at 1, a direction bit of 1 sets only the high-side enable and a direction bit of 0 sets only the low-side enable. The outputs follow the inputs in the same cycle.
- R3: No channel ever has its high-side and low-side enables at 1 together.
- R4: In normal operation, an overcurrent on a channel turns that channel's gate enables off in the same cycle. From the next rising edge the fault is latched for that channel, the fault flag is 0, and the channel's gates stay off while its enable is 1. Other channels keep following their inputs.
- R5: In normal operation, a 1-to-0 transition of the clear input clears all latched faults on the third rising edge after the low level is first sampled. The fault flag then returns to 1, and each cleared channel follows its direction and enable inputs again.
- R6: If an overcurrent is present on a channel in the cycle in which the clear takes effect, that channel's fault stays latched.
- R7: From the rising edge at which the sleep input is sampled low, all gate enables and the charge-pump enable are 0 for as long as the sleep input stays low.
- R8: While asleep, changes on the direction, enable, overcurrent and clear inputs have no effect. No fault is latched or cleared, and after wake-up each channel is in the same fault state as before sleep.
- R9: On the first rising edge that samples the sleep input high after sleep, the charge-pump enable becomes 1. The gate enables stay 0, and overcurrent and clear inputs are ignored, for a further WAKE_CYCLES rising edges. Only then does normal operation resume.
- R10: The fault flag keeps its value throughout sleep and wake-up.
- R11: If the sleep input goes low during the wake-up time, the block returns to sleep. A later rise restarts the full wake-up time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sleep_n | input | 1 | Active-low sleep request; low means sleep |
| clr_fault | input | 1 | Fault clear; a 1-to-0 transition clears all latched faults |
| dir_in | input | NUM_CH | Per-channel direction: 1 selects the high side, 0 the low side |
| ch_en | input | NUM_CH | Per-channel enable |
| oc_det | input | NUM_CH | Per-channel overcurrent detect, active high |
| gate_hi | output | NUM_CH | Per-channel high-side gate enable |
| gate_lo | output | NUM_CH | Per-channel low-side gate enable |
| pump_en | output | 1 | Charge-pump enable |
| fault_n | output | 1 | Active-low flag, 0 while any fault is latched |

## Verification
Several direction and enable patterns are applied across the channels while all channels are healthy. These separate correct decoding from swapped sides or ignored enables. A fault on one channel while its neighbours are enabled shows that latching and masking stay per channel. A clear with the overcurrent still held, checked against a clear after the overcurrent drops, separates detect priority from plain clearing. During sleep and during a wake-up that is cut short, the inputs are toggled and clear edges are applied. The number of edges until the gates come back is counted, which exposes an ignored freeze, a lost latch or a counter that does not restart.

// File: rtl/bguard_pkg.sv
package bguard_pkg;
  typedef enum logic [1:0] {
    PS_SLEEP = 2'd0,
    PS_WAKE  = 2'd1,
    PS_RUN   = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/bguard_rst_sync.sv
// Two-stage reset synchroniser: asserts at once, releases on the clock.
module bguard_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/bguard_edge_sync.sv
// Two-flop synchroniser plus falling-edge detect, with a clock enable
// that freezes the chain while the block sleeps.
module bguard_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ena,
  input  logic din,
  output logic fall
);
  logic meta_q, sync_q, prev_q;
  logic meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = meta_q;
    sync_d = sync_q;
    prev_d = prev_q;
    if (ena) begin
      meta_d = din;
      sync_d = meta_q;
      prev_d = sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~sync_q;
endmodule

// File: rtl/bguard_pwr_seq.sv
// Sleep / wake-up / run sequencer with a wake-up cycle counter.
module bguard_pwr_seq
  import bguard_pkg::*;
#(
  parameter int WAKE_CYCLES = 250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  output logic run,
  output logic awake
);
  localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

  pwr_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_SLEEP: begin
        if (sleep_n) begin
          state_d = PS_WAKE;
          cnt_d   = '0;
        end
      end
      PS_WAKE: begin
        if (!sleep_n)          state_d = PS_SLEEP;
        else if (cnt_q == LAST) state_d = PS_RUN;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      PS_RUN: begin
        if (!sleep_n) state_d = PS_SLEEP;
      end
      default: state_d = PS_SLEEP;
    endcase
  end

  // Counter clock enable: only loads on wake entry or counts while waking.
  assign cnt_en = (state_q == PS_WAKE) || ((state_q == PS_SLEEP) && sleep_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_SLEEP;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign run   = (state_q == PS_RUN);
  assign awake = (state_q != PS_SLEEP);
endmodule

// File: rtl/bguard_channel.sv
// One half-channel: fault latch and gate decode.
module bguard_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr_pulse,
  input  logic oc,
  input  logic dir,
  input  logic en,
  output logic gate_hi,
  output logic gate_lo,
  output logic fault
);
  logic flt_q, flt_d;
  logic drive;

  // Detection wins over clearing in the same cycle.
  always_comb begin
    flt_d = flt_q;
    if (run && oc)             flt_d = 1'b1;
    else if (run && clr_pulse) flt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= 1'b0;
    else        flt_q <= flt_d;
  end

  assign drive   = run & en & ~flt_q & ~oc;
  assign gate_hi = drive & dir;
  assign gate_lo = drive & ~dir;
  assign fault   = flt_q;
endmodule

// File: rtl/bridge_guard.sv
module bridge_guard #(
  parameter int NUM_CH      = 4,
  parameter int WAKE_CYCLES = 250_000  // 1 ms at 250 MHz
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_n,
  input  logic              clr_fault,
  input  logic [NUM_CH-1:0] dir_in,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] oc_det,
  output logic [NUM_CH-1:0] gate_hi,
  output logic [NUM_CH-1:0] gate_lo,
  output logic              pump_en,
  output logic              fault_n
);
  logic rst_sync_n;
  logic run_q;
  logic awake;
  logic clr_pulse;
  logic [NUM_CH-1:0] ch_fault;

  bguard_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  bguard_pwr_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sleep_n (sleep_n),
    .run     (run_q),
    .awake   (awake)
  );

  bguard_edge_sync u_clr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ena   (awake),
    .din   (clr_fault),
    .fall  (clr_pulse)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    bguard_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .run       (run_q),
      .clr_pulse (clr_pulse),
      .oc        (oc_det[i]),
      .dir       (dir_in[i]),
      .en        (ch_en[i]),
      .gate_hi   (gate_hi[i]),
      .gate_lo   (gate_lo[i]),
      .fault     (ch_fault[i])
    );
  end

  assign pump_en = awake;
  assign fault_n = ~|ch_fault;
endmodule

// File: rtl/bguard_chk.sv
module bguard_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              arst_n,
  input logic              srst_n,
  input logic              sleep_n,
  input logic              run,
  input logic [NUM_CH-1:0] oc_det,
  input logic [NUM_CH-1:0] gate_hi,
  input logic [NUM_CH-1:0] gate_lo,
  input logic              pump_en,
  input logic              fault_n
);
  always @(negedge clk) begin
    if (!arst_n) begin
      assert_reset_quiet_R1: assert (!pump_en && fault_n && gate_hi == '0 && gate_lo == '0);
    end
  end

  assert_no_shoot_through_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (gate_hi & gate_lo) == '0);

  assert_oc_masks_gates_R4: assert property (@(posedge clk) disable iff (!srst_n)
    ((gate_hi | gate_lo) & oc_det) == '0);

  assert_oc_latches_flag_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (run && (|oc_det)) |=> !fault_n);

  assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (!srst_n)
    !sleep_n |=> (!pump_en && gate_hi == '0 && gate_lo == '0));

  assert_wake_gates_off_R9: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(sleep_n) |=> (pump_en && gate_hi == '0 && gate_lo == '0));

  assert_flag_held_asleep_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (!sleep_n && $past(!sleep_n)) |=> $stable(fault_n));
endmodule

bind bridge_guard bguard_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .arst_n  (rst_n),
  .srst_n  (rst_sync_n),
  .sleep_n (sleep_n),
  .run     (run_q),
  .oc_det  (oc_det),
  .gate_hi (gate_hi),
  .gate_lo (gate_lo),
  .pump_en (pump_en),
  .fault_n (fault_n)
);

// File: tb/bridge_guard_bench.sv
`timescale 1ns/1ps
module bridge_guard_bench;
  localparam int N = 4;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_n = 1'b0;
  logic clr_fault = 1'b1;
  logic [N-1:0] dir_in = '0;
  logic [N-1:0] ch_en = '0;
  logic [N-1:0] oc_det = '0;
  logic [N-1:0] gate_hi, gate_lo;
  logic pump_en, fault_n;

  always #2 clk = ~clk;

  bridge_guard #(.NUM_CH(N), .WAKE_CYCLES(W)) u_bridge_guard (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .clr_fault(clr_fault),
    .dir_in(dir_in), .ch_en(ch_en), .oc_det(oc_det),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .pump_en(pump_en), .fault_n(fault_n)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string phase = "R1";

  // Behavioural reference state.
  bit rs1, rs2;
  bit c1, c2, c3;
  int mstate;   // 0 sleep, 1 waking, 2 running
  int wcnt;
  bit [N-1:0] flt;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset_core();
    c1 = 0; c2 = 0; c3 = 0;
    mstate = 0; wcnt = 0; flt = '0;
  endtask

  task automatic model_step();
    bit run, fall;
    if (!rst_n) begin
      rs1 = 0; rs2 = 0;
      model_reset_core();
      return;
    end
    if (!rs2) begin
      rs2 = rs1; rs1 = 1;
      model_reset_core();
      return;
    end
    run  = (mstate == 2);
    fall = c3 && !c2;
    for (int i = 0; i < N; i++) begin
      if (run && oc_det[i])  flt[i] = 1;
      else if (run && fall)  flt[i] = 0;
    end
    if (mstate != 0) begin
      c3 = c2; c2 = c1; c1 = clr_fault;
    end
    case (mstate)
      0: if (sleep_n) begin mstate = 1; wcnt = 0; end
      1: if (!sleep_n) mstate = 0;
         else if (wcnt == W - 1) mstate = 2;
         else wcnt++;
      default: if (!sleep_n) mstate = 0;
    endcase
  endtask

  task automatic compare();
    logic [N-1:0] eh, el;
    bit ep, ef;
    for (int i = 0; i < N; i++) begin
      bit d;
      d = (mstate == 2) && ch_en[i] && !flt[i] && !oc_det[i];
      eh[i] = d && dir_in[i];
      el[i] = d && !dir_in[i];
    end
    ep = (mstate != 0);
    ef = (flt == '0);
    chk(phase, 32'({gate_hi, gate_lo, pump_en, fault_n}), 32'({eh, el, ep, ef}));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    model_reset_core();
    rs1 = 0; rs2 = 0;
    // R1: reset state
    phase = "R1";
    ticks(3);
    chk("R1 reset outputs", 32'({gate_hi, gate_lo, pump_en, fault_n}), 32'({8'h00, 1'b0, 1'b1}));
    rst_n = 1'b1;
    ticks(3);

    // R9: wake-up after first sleep release
    phase = "R9";
    sleep_n = 1'b1; ch_en = '1; dir_in = 4'b1010;
    tick();
    chk("R9 pump on at wake", 32'(pump_en), 32'd1);
    chk("R9 gates off at wake", 32'({gate_hi, gate_lo}), 32'd0);
    ticks(W);
    chk("R9 running after delay", 32'(gate_hi), 32'(4'b1010));

    // R2: decode patterns
    phase = "R2";
    chk("R2 lo side", 32'(gate_lo), 32'(4'b0101));
    ch_en = 4'b0000; tick();
    chk("R2 enable low", 32'({gate_hi, gate_lo}), 32'd0);
    ch_en = 4'b0110; dir_in = 4'b0011; tick();
    chk("R2 mixed hi", 32'(gate_hi), 32'(4'b0010));
    chk("R2 mixed lo", 32'(gate_lo), 32'(4'b0100));
    ch_en = 4'b1111; dir_in = 4'b1111; ticks(2);

    // R4: overcurrent on channel 1
    phase = "R4";
    oc_det = 4'b0010; tick();
    oc_det = 4'b0000; tick();
    chk("R4 flag low", 32'(fault_n), 32'd0);
    chk("R4 ch1 masked others run", 32'(gate_hi), 32'(4'b1101));
    ticks(2);

    // R5: clear with falling edge
    phase = "R5";
    clr_fault = 1'b0; ticks(2);
    chk("R5 not yet cleared", 32'(fault_n), 32'd0);
    tick();
    chk("R5 cleared on third edge", 32'(fault_n), 32'd1);
    chk("R5 ch1 follows inputs", 32'(gate_hi), 32'(4'b1111));
    clr_fault = 1'b1; ticks(3);

    // R6: detect wins over clear
    phase = "R6";
    oc_det = 4'b0100; tick();
    clr_fault = 1'b0; ticks(4);
    chk("R6 still latched", 32'(fault_n), 32'd0);
    oc_det = 4'b0000; clr_fault = 1'b1; ticks(3);
    chk("R6 no clear on level", 32'(fault_n), 32'd0);
    clr_fault = 1'b0; ticks(4);
    chk("R6 cleared after oc drop", 32'(fault_n), 32'd1);
    clr_fault = 1'b1; ticks(3);

    // R7/R8/R10: sleep with a latched fault on channel 0
    phase = "R7";
    oc_det = 4'b0001; tick(); oc_det = '0; tick();
    sleep_n = 1'b0; tick();
    chk("R7 pump off", 32'(pump_en), 32'd0);
    chk("R7 gates off", 32'({gate_hi, gate_lo}), 32'd0);
    phase = "R8";
    dir_in = 4'b0000; ch_en = 4'b0101; oc_det = 4'b1000; ticks(2);
    clr_fault = 1'b0; ticks(3); clr_fault = 1'b1; ticks(3);
    oc_det = 4'b0000; ch_en = 4'b1111; dir_in = 4'b1111; tick();
    chk("R10 flag held asleep", 32'(fault_n), 32'd0);
    sleep_n = 1'b1;
    phase = "R9";
    oc_det = 4'b1000; ticks(3);
    clr_fault = 1'b0; ticks(3);
    oc_det = 4'b0000; clr_fault = 1'b1;
    ticks(W - 6 + 1);
    phase = "R8";
    chk("R8 ch3 not latched, ch0 kept", 32'(gate_hi), 32'(4'b1110));
    chk("R10 flag kept through wake", 32'(fault_n), 32'd0);

    // R11: sleep during wake restarts the timer
    phase = "R11";
    sleep_n = 1'b0; ticks(2);
    sleep_n = 1'b1; ticks(5);
    sleep_n = 1'b0; tick();
    sleep_n = 1'b1;
    begin
      int n = 0;
      while (gate_hi == '0 && n < 3 * W) begin tick(); n++; end
      chk("R11 full wake restarted", 32'(n), 32'(W + 1));
    end

    // R5 again: final clear brings channel 0 back
    phase = "R5";
    clr_fault = 1'b0; ticks(4);
    chk("R5 ch0 restored", 32'(gate_hi), 32'(4'b1111));
    clr_fault = 1'b1; ticks(2);
    finish_run();
  end
endmodule